// File: doc/BRIEF.md
# DMA Command Queue with Final-Transfer Tag

This block sits in front of the DMA engine of a bitstream configuration port. Software programs a transfer by writing four registers: source byte address, destination address, source word count and destination word count. The write to the destination-count register closes the set and queues it as one command in a small FIFO. An engine takes commands from the head of the FIFO one at a time and streams the requested number of 32-bit words to a downstream port over a valid/ready handshake. It fetches each word from a simple combinational word-source interface that stands in for memory.

Source addresses are 8-byte aligned, so bit 0 of the source address is free to mark the final command of a configuration. Every finished command gives a one-cycle DMA-done pulse. A command marked final also gives a port-done pulse, and only after the downstream port has accepted its last word. The block reports queue full and empty, and it records two sticky errors: a command written while the queue is full, and a command it cannot run. Either error stops the engine from taking further commands until the queue is cleared. A start request is answered with "ok" only when the queue is empty and not full, and with "busy" otherwise.

Top module: `cfg_dma_cmdq`

## Requirements
- R1: After reset the queue reports empty=1 and full=0, the downstream valid is 0, both error flags are 0 and no event pulses.
- R2: A write to offset 0x24 (destination count) pushes the staged command, formed from offsets 0x18 (source address), 0x1C (destination address) and 0x20 (source word count). Full is 1 when DEPTH commands are held and empty is 1 when none are held.
- R3: A write to offset 0x24 while the queue is full drops that command, sets the overflow error and leaves the held commands unchanged.
- R4: A command streams exactly its source word count of words. Each word is read from the word source at byte address (source address with bits 2:0 cleared) plus 4 times the word index, and is passed unchanged to the downstream data.
- R5: Commands run strictly in push order, and a command does not start until the previous one has finished.
- R6: Each command gives exactly one single-cycle DMA-done pulse, in the cycle after its last word is accepted. A command with a count of zero gives its pulse without sending any word.
- R7: Port-done pulses only for commands whose source address bit 0 is 1. It pulses in the same cycle as that command's DMA-done, after all of that command's words have been accepted.
- R8: While valid is high and ready is low, valid stays high and the source address holds, so no word is skipped or repeated.
- R9: A command is illegal, and is dropped with the command error set, when source address bits 2:1 are nonzero, or the destination address is not all ones, or the destination count is nonzero.
- R10: While either error flag is set, no further command is taken from the queue. A queue-clear pulse empties the queue and clears both errors, and commands then run again.
- R11: A start request gives start_ok one cycle later when the queue is empty, and start_busy one cycle later otherwise. The two never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register byte offset |
| wr_data | input | 32 | Register write data |
| q_clear | input | 1 | Empties the queue and clears the errors |
| cfg_start | input | 1 | Request to begin a configuration |
| q_full | output | 1 | Queue holds DEPTH commands |
| q_empty | output | 1 | Queue holds no command |
| err_overflow | output | 1 | Sticky: command written while full |
| err_command | output | 1 | Sticky: illegal command written |
| start_ok | output | 1 | Start accepted, one-cycle pulse |
| start_busy | output | 1 | Start refused, one-cycle pulse |
| src_addr | output | 32 | Byte address of the word being fetched |
| src_data | input | 32 | Word returned by the word source |
| dn_valid | output | 1 | Downstream word valid |
| dn_data | output | 32 | Downstream word |
| dn_ready | input | 1 | Downstream accepts the word |
| dma_done | output | 1 | Command finished, one-cycle pulse |
| port_done | output | 1 | Final command drained downstream, one-cycle pulse |

## Verification
A single three-word command with ready held high checks the address walk and the word count. A mix of an unaligned-looking base, a zero-count command and a tagged command checks ordering. It also shows that port-done follows only the tagged command and only after its last word. A ready pattern that is high one cycle in three separates correct holding from dropped or repeated words. Filling the queue while the downstream stalls, then overflowing it, shows where the halt starts and where a clear lets commands run again. Three kinds of illegal command each check one legality rule on its own.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [7:0] OFS_SRC_ADDR = 8'h18;
  localparam logic [7:0] OFS_DST_ADDR = 8'h1C;
  localparam logic [7:0] OFS_SRC_LEN  = 8'h20;
  localparam logic [7:0] OFS_DST_LEN  = 8'h24;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_FIN  = 2'd2
  } eng_state_t;

  function automatic logic [WORD_W-1:0] word_base(input logic [WORD_W-1:0] src);
    return {src[WORD_W-1:3], 3'b000};
  endfunction

  function automatic logic final_tag(input logic [WORD_W-1:0] src);
    return src[0];
  endfunction

  function automatic logic [WORD_W-1:0] step_addr(input logic [WORD_W-1:0] a);
    return a + WORD_W'(4);
  endfunction

  function automatic logic cmd_legal(input logic [WORD_W-1:0] src,
                                     input logic [WORD_W-1:0] dst,
                                     input logic [WORD_W-1:0] dlen);
    return (src[2:1] == 2'b00) && (&dst) && (dlen == '0);
  endfunction

endpackage

// File: rtl/cdq_regs.sv
module cdq_regs
  import cfg_dma_pkg::*;
#(
  parameter int unsigned REG_AW = 8,
  parameter int unsigned LEN_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                clr,
  input  logic                q_full,
  output logic                push,
  output logic [WORD_W-1:0]   push_src,
  output logic [LEN_W-1:0]    push_len,
  output logic                ovf_evt,
  output logic                bad_evt,
  output logic                err_ovf,
  output logic                err_cmd
);

  logic [WORD_W-1:0] stg_src;
  logic [WORD_W-1:0] stg_dst;
  logic [LEN_W-1:0]  stg_len;
  logic              close_wr;

  assign close_wr = wr_en && (wr_addr == REG_AW'(OFS_DST_LEN)) && !clr;
  assign ovf_evt  = close_wr && q_full;
  assign bad_evt  = close_wr && !q_full && !cmd_legal(stg_src, stg_dst, wr_data);
  assign push     = close_wr && !q_full && cmd_legal(stg_src, stg_dst, wr_data);
  assign push_src = stg_src;
  assign push_len = stg_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_src <= '0;
      stg_dst <= '1;
      stg_len <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_AW'(OFS_SRC_ADDR)) stg_src <= wr_data;
      if (wr_addr == REG_AW'(OFS_DST_ADDR)) stg_dst <= wr_data;
      if (wr_addr == REG_AW'(OFS_SRC_LEN))  stg_len <= wr_data[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_ovf <= 1'b0;
      err_cmd <= 1'b0;
    end else if (clr) begin
      err_ovf <= 1'b0;
      err_cmd <= 1'b0;
    end else begin
      err_ovf <= err_ovf | ovf_evt;
      err_cmd <= err_cmd | bad_evt;
    end
  end

endmodule

// File: rtl/cdq_fifo.sv
module cdq_fifo #(
  parameter int unsigned W     = 48,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rp];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mem[g] <= '0;
      else if (do_push && wp == PTR_W'(g))      mem[g] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wrap_inc(wp);
      if (do_pop)  rp <= wrap_inc(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/cdq_engine.sv
module cdq_engine
  import cfg_dma_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              head_vld,
  input  logic [WORD_W-1:0] head_src,
  input  logic [LEN_W-1:0]  head_len,
  output logic              pop,
  output logic [WORD_W-1:0] src_addr,
  input  logic [WORD_W-1:0] src_data,
  output logic              dn_valid,
  output logic [WORD_W-1:0] dn_data,
  input  logic              dn_ready,
  output logic              dma_done,
  output logic              port_done
);

  eng_state_t        st;
  logic [WORD_W-1:0] cur;
  logic [LEN_W-1:0]  rem;
  logic              tag;
  logic              xfer;

  assign pop       = (st == ENG_IDLE) && head_vld && !halt;
  assign dn_valid  = (st == ENG_RUN);
  assign xfer      = dn_valid && dn_ready;
  assign src_addr  = cur;
  assign dn_data   = src_data;
  assign dma_done  = (st == ENG_FIN);
  assign port_done = (st == ENG_FIN) && tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ENG_IDLE;
      cur <= '0;
      rem <= '0;
      tag <= 1'b0;
    end else begin
      case (st)
        ENG_IDLE: if (pop) begin
          cur <= word_base(head_src);
          rem <= head_len;
          tag <= final_tag(head_src) && (head_src[2:1] == 2'b00);
          st  <= (head_len == '0) ? ENG_FIN : ENG_RUN;
        end
        ENG_RUN: if (xfer) begin
          cur <= step_addr(cur);
          rem <= rem - 1'b1;
          if (rem == LEN_W'(1)) st <= ENG_FIN;
        end
        ENG_FIN: st <= ENG_IDLE;
        default: st <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_dma_cmdq.sv
module cfg_dma_cmdq
  import cfg_dma_pkg::*;
#(
  parameter int unsigned REG_AW = 8,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              q_clear,
  input  logic              cfg_start,
  output logic              q_full,
  output logic              q_empty,
  output logic              err_overflow,
  output logic              err_command,
  output logic              start_ok,
  output logic              start_busy,
  output logic [31:0]       src_addr,
  input  logic [31:0]       src_data,
  output logic              dn_valid,
  output logic [31:0]       dn_data,
  input  logic              dn_ready,
  output logic              dma_done,
  output logic              port_done
);

  localparam int unsigned CMD_W = WORD_W + LEN_W;

  logic              push_evt, pop_evt, ovf_evt, bad_evt, halt;
  logic [WORD_W-1:0] push_src;
  logic [LEN_W-1:0]  push_len;
  logic [CMD_W-1:0]  head;

  assign halt = err_overflow || err_command;

  cdq_regs #(.REG_AW(REG_AW), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr(q_clear), .q_full(q_full), .push(push_evt), .push_src(push_src),
    .push_len(push_len), .ovf_evt(ovf_evt), .bad_evt(bad_evt),
    .err_ovf(err_overflow), .err_cmd(err_command)
  );

  cdq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(q_clear), .push(push_evt),
    .din({push_src, push_len}), .pop(pop_evt), .dout(head),
    .full(q_full), .empty(q_empty)
  );

  cdq_engine #(.LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .halt(halt), .head_vld(!q_empty),
    .head_src(head[CMD_W-1:LEN_W]), .head_len(head[LEN_W-1:0]), .pop(pop_evt),
    .src_addr(src_addr), .src_data(src_data), .dn_valid(dn_valid),
    .dn_data(dn_data), .dn_ready(dn_ready), .dma_done(dma_done),
    .port_done(port_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_ok   <= 1'b0;
      start_busy <= 1'b0;
    end else begin
      start_ok   <= cfg_start && q_empty && !q_full;
      start_busy <= cfg_start && !(q_empty && !q_full);
    end
  end

endmodule

// File: rtl/cfg_dma_cmdq_chk.sv
module cfg_dma_cmdq_chk #(
  parameter int unsigned REG_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              q_clear,
  input logic              q_full,
  input logic              q_empty,
  input logic              err_overflow,
  input logic              err_command,
  input logic              start_ok,
  input logic              start_busy,
  input logic [31:0]       src_addr,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic              dma_done,
  input logic              port_done,
  input logic              pop_evt
);

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty)); // R2

  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_AW'(8'h24) && q_full && !q_clear) |=> err_overflow); // R3

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(src_addr))); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> !dma_done); // R6

  AST_PORT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    port_done |-> (dma_done && !dn_valid)); // R7

  AST_BAD_DSTLEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_AW'(8'h24) && !q_full && !q_clear && wr_data != 32'd0)
      |=> err_command); // R9

  AST_HALT_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overflow || err_command) |-> !pop_evt); // R10

  AST_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok && start_busy)); // R11

endmodule

bind cfg_dma_cmdq cfg_dma_cmdq_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .q_clear(q_clear), .q_full(q_full), .q_empty(q_empty),
  .err_overflow(err_overflow), .err_command(err_command),
  .start_ok(start_ok), .start_busy(start_busy), .src_addr(src_addr),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dma_done(dma_done),
  .port_done(port_done), .pop_evt(pop_evt)
);

// File: tb/cfg_dma_cmdq_bench.sv
module cfg_dma_cmdq_bench;

  localparam int DEPTH = 4;
  localparam logic [31:0] MIX = 32'h5A00_00C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic q_clear = 1'b0, cfg_start = 1'b0, dn_ready = 1'b0;
  logic q_full, q_empty, err_overflow, err_command, start_ok, start_busy;
  logic [31:0] src_addr, src_data, dn_data;
  logic dn_valid, dma_done, port_done;

  always #4 clk = ~clk;

  assign src_data = src_addr ^ MIX;

  cfg_dma_cmdq u_cfg_dma_cmdq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .q_clear(q_clear), .cfg_start(cfg_start), .q_full(q_full), .q_empty(q_empty),
    .err_overflow(err_overflow), .err_command(err_command), .start_ok(start_ok),
    .start_busy(start_busy), .src_addr(src_addr), .src_data(src_data),
    .dn_valid(dn_valid), .dn_data(dn_data), .dn_ready(dn_ready),
    .dma_done(dma_done), .port_done(port_done)
  );

  int errors = 0, checks = 0;
  int wcount = 0, dcount = 0, pcount = 0, p_wc = 0, ecount = 0;
  logic [31:0] wlog [256];
  logic [31:0] elog [256];
  int bp_mode = 0;
  int cyc = 0;

  always @(negedge clk) begin
    if (dn_valid && dn_ready) begin
      wlog[wcount] = dn_data;
      wcount = wcount + 1;
    end
    if (dma_done) dcount = dcount + 1;
    if (port_done) begin
      pcount = pcount + 1;
      p_wc = wcount;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bp_mode == 1) dn_ready <= #1 ((cyc % 3) == 0);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1 wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic push_cmd(input logic [31:0] src, input logic [31:0] len,
                          input logic [31:0] dst, input logic [31:0] dlen);
    wr(8'h18, src); wr(8'h1C, dst); wr(8'h20, len); wr(8'h24, dlen);
  endtask

  task automatic expect_words(input logic [31:0] src, input int len);
    for (int k = 0; k < len; k++) begin
      elog[ecount] = ({src[31:3], 3'b000} + 32'(4 * k)) ^ MIX;
      ecount++;
    end
  endtask

  task automatic verify_words(input string req);
    int bad = 0;
    chk(wcount == ecount, req, wcount, ecount);
    for (int k = 0; k < ecount && k < wcount; k++) begin
      if (wlog[k] !== elog[k]) begin
        if (bad == 0) chk(1'b0, req, wlog[k], elog[k]);
        bad++;
      end
    end
    if (bad == 0) chk(1'b1, req, 0, 0);
  endtask

  task automatic wait_done(input int target);
    for (int i = 0; i < 3000 && dcount < target; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(posedge clk); #1 q_clear = 1'b1;
    @(posedge clk); #1 q_clear = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(q_empty === 1'b1 && q_full === 1'b0, "R1 queue status", {q_full, q_empty}, 2'b01);
    chk(dn_valid === 1'b0 && dma_done === 1'b0 && port_done === 1'b0, "R1 idle outputs",
        {dn_valid, dma_done, port_done}, 0);
    chk(err_overflow === 1'b0 && err_command === 1'b0, "R1 errors", {err_overflow, err_command}, 0);
  endtask

  task automatic t_single();
    int d0 = dcount, p0 = pcount;
    dn_ready = 1'b1;
    push_cmd(32'h0000_1000, 3, 32'hFFFF_FFFF, 0);
    expect_words(32'h0000_1000, 3);
    wait_done(d0 + 1);
    idle(4);
    verify_words("R4 single command words");
    chk(dcount == d0 + 1, "R6 one done per command", dcount - d0, 1);
    chk(pcount == p0, "R7 no port-done without tag", pcount - p0, 0);
  endtask

  task automatic t_order();
    int d0 = dcount, p0 = pcount;
    dn_ready = 1'b1;
    push_cmd(32'h0000_2004 & 32'hFFFF_FFF8, 2, 32'hFFFF_FFFF, 0);
    expect_words(32'h0000_2000, 2);
    push_cmd(32'h0000_3000, 0, 32'hFFFF_FFFF, 0);
    push_cmd(32'h0000_4009, 2, 32'hFFFF_FFFF, 0);
    expect_words(32'h0000_4008, 2);
    wait_done(d0 + 3);
    idle(4);
    verify_words("R5 push-order words");
    chk(dcount == d0 + 3, "R6 zero-count command still done", dcount - d0, 3);
    chk(pcount == p0 + 1, "R7 one port-done for tagged command", pcount - p0, 1);
    chk(p_wc == ecount, "R7 port-done after last word", p_wc, ecount);
  endtask

  task automatic t_backpressure();
    int d0 = dcount;
    bp_mode = 1;
    push_cmd(32'h0000_5000, 5, 32'hFFFF_FFFF, 0);
    expect_words(32'h0000_5000, 5);
    wait_done(d0 + 1);
    bp_mode = 0;
    idle(3);
    dn_ready = 1'b1;
    verify_words("R8 words under backpressure");
  endtask

  task automatic t_full_halt();
    int d0;
    dn_ready = 1'b0;
    idle(2);
    d0 = dcount;
    push_cmd(32'h0000_7000, 2, 32'hFFFF_FFFF, 0);
    expect_words(32'h0000_7000, 2);
    idle(4);
    chk(q_empty === 1'b1, "R2 head taken by engine", q_empty, 1);
    for (int n = 0; n < DEPTH; n++)
      push_cmd(32'h0000_8000 + 32'(n * 32'h100), 1, 32'hFFFF_FFFF, 0);
    chk(q_full === 1'b1 && q_empty === 1'b0, "R2 full after DEPTH pushes", {q_full, q_empty}, 2'b10);
    push_cmd(32'h0000_9000, 1, 32'hFFFF_FFFF, 0);
    chk(err_overflow === 1'b1, "R3 overflow flag", err_overflow, 1);
    chk(q_full === 1'b1, "R3 queue unchanged", q_full, 1);
    dn_ready = 1'b1;
    wait_done(d0 + 1);
    idle(20);
    chk(dcount == d0 + 1 && q_empty === 1'b0 && dn_valid === 1'b0, "R10 halted after error",
        dcount - d0, 1);
    pulse_clear();
    @(negedge clk);
    chk(q_empty === 1'b1 && err_overflow === 1'b0, "R10 clear empties and clears",
        {q_empty, err_overflow}, 2'b10);
    verify_words("R3 only pre-halt command ran");
  endtask

  task automatic t_bad();
    int d0 = dcount;
    dn_ready = 1'b1;
    push_cmd(32'h0000_6002, 1, 32'hFFFF_FFFF, 0);
    chk(err_command === 1'b1 && q_empty === 1'b1, "R9 misaligned source", {err_command, q_empty}, 2'b11);
    pulse_clear();
    push_cmd(32'h0000_6000, 1, 32'h0000_0000, 0);
    chk(err_command === 1'b1 && q_empty === 1'b1, "R9 real destination", {err_command, q_empty}, 2'b11);
    pulse_clear();
    push_cmd(32'h0000_6000, 1, 32'hFFFF_FFFF, 4);
    chk(err_command === 1'b1 && q_empty === 1'b1, "R9 nonzero destination count", {err_command, q_empty}, 2'b11);
    pulse_clear();
    chk(err_command === 1'b0, "R10 clear resets command error", err_command, 0);
    push_cmd(32'h0000_6001, 2, 32'hFFFF_FFFF, 0);
    expect_words(32'h0000_6000, 2);
    wait_done(d0 + 1);
    idle(3);
    verify_words("R10 runs again after clear");
  endtask

  task automatic t_start();
    int d0 = dcount;
    dn_ready = 1'b1;
    idle(2);
    @(posedge clk); #1 cfg_start = 1'b1;
    @(posedge clk); #1 cfg_start = 1'b0;
    chk(start_ok === 1'b1 && start_busy === 1'b0, "R11 start accepted when empty",
        {start_ok, start_busy}, 2'b10);
    dn_ready = 1'b0;
    push_cmd(32'h0000_A000, 1, 32'hFFFF_FFFF, 0);
    push_cmd(32'h0000_B000, 1, 32'hFFFF_FFFF, 0);
    expect_words(32'h0000_A000, 1);
    expect_words(32'h0000_B000, 1);
    @(posedge clk); #1 cfg_start = 1'b1;
    @(posedge clk); #1 cfg_start = 1'b0;
    chk(start_busy === 1'b1 && start_ok === 1'b0, "R11 start refused when not empty",
        {start_ok, start_busy}, 2'b01);
    dn_ready = 1'b1;
    wait_done(d0 + 2);
    idle(3);
    verify_words("R5 queued commands drain");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_single();
    t_order();
    t_backpressure();
    t_full_halt();
    t_bad();
    t_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

endmodule